// File: doc/BRIEF.md
# Computation-Sharing Unsigned Multiplier

This block multiplies an unsigned 8-bit operand `x_i` by an unsigned 8-bit coefficient `c_i` and returns the 16-bit product. It has no partial-product array. A shared bank forms the odd multiples 1x, 3x, 5x up to 15x once. Each 4-bit slice of the coefficient is then rewritten as one odd value times a power of two. A select unit picks that odd multiple from the bank, shifts it left and gates it to zero for an all-zero slice. A final adder sums the slice results, each weighted by its slice position.

The same bank can serve many coefficients at once. This makes the structure a natural building block for the multiplier column of a transposed FIR tap array, where one sample meets every coefficient in the same cycle. Operand width, slice width and the presence of the output register are parameters. The default build registers the product, giving one cycle of latency, and uses a synchronous active-low reset.

Top module: `csm_mult`

## Requirements
- R1: With the output register enabled, `prod_o` equals `x_i * c_i` sampled at the previous rising edge, for all 65536 unsigned operand pairs.
- R2: While `rst_n` is low at a rising edge, `prod_o` is 0 after that edge.
- R3: Each 4-bit coefficient slice is encoded as a shift code equal to its count of trailing zeros, plus a select code equal to (odd part − 1)/2. For example, 0110 encodes as select 001 and shift 01, 1000 as select 000 and shift 11, 1011 as select 101 and shift 00, and 1111 as select 111 and shift 00. The select unit output is the chosen odd multiple shifted left by the shift code.
- R4: A coefficient slice of 0000 contributes zero to the product. For example, c = 0x00 gives 0, and c = 0xA0 gives 160·x.
- R5: The result of the upper slice (bits 7:4) is weighted by 16 before the final add. For example, c = 0xE4 gives 4·x + (14·x << 4) = 228·x.
- R6: The bank entry k holds (2k+1)·x, with entries spaced 2·x apart and the largest entry 15·x. The extreme operands 255 × 0x0F = 3825 and 255 × 255 = 65025 are produced without loss.
- R7: A change on the inputs leaves `prod_o` unchanged until the next rising edge. After that edge `prod_o` shows the new product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| x_i | input | 8 | Unsigned data operand |
| c_i | input | 8 | Unsigned coefficient operand |
| prod_o | output | 16 | Unsigned product |

## Verification
The bench builds the block with its defaults: an 8-bit operand, an 8-bit coefficient split into two 4-bit slices, and the output register on. With these values the full operand space of 65536 pairs is small enough to sweep in a single stream, one pair per cycle. Directed cases add the slice encodings from R3, zero slices in either position, the upper-slice weighting and the extreme operands. A latency probe samples the output just after an input change and again after the next edge.

// File: rtl/csm_pkg.sv
package csm_pkg;
   localparam int unsigned CSM_DEF_X_W   = 8;
   localparam int unsigned CSM_DEF_C_W   = 8;
   localparam int unsigned CSM_DEF_NIB_W = 4;

   // odd alphabet member for bank index k
   function automatic int unsigned csm_odd(input int unsigned k);
      return 2 * k + 1;
   endfunction
endpackage

// File: rtl/csm_bank.sv
module csm_bank #(
   parameter int unsigned X_W   = 8,
   parameter int unsigned NIB_W = 4,
   localparam int unsigned ALPHA_N = 2 ** (NIB_W - 1),
   localparam int unsigned BW      = X_W + NIB_W
) (
   input  logic [X_W-1:0]              x_i,
   output logic [ALPHA_N-1:0][BW-1:0]  bank_o
);
   import csm_pkg::*;

   for (genvar k = 0; k < ALPHA_N; k++) begin : g_mult
      assign bank_o[k] = BW'(x_i) * BW'(csm_odd(k));
      if (k > 0) begin : g_chk
         // R6: neighbouring entries differ by exactly 2x
         always_comb begin
            a_r6_bank_step : assert (bank_o[k] - bank_o[k-1] == BW'({x_i, 1'b0}))
               else $error("bank step mismatch at entry %0d", k);
         end
      end
   end
endmodule

// File: rtl/csm_encoder.sv
module csm_encoder #(
   parameter int unsigned NIB_W = 4,
   localparam int unsigned SEL_W = NIB_W - 1,
   localparam int unsigned SHF_W = (NIB_W > 2) ? $clog2(NIB_W) : 1
) (
   input  logic [NIB_W-1:0] nib_i,
   output logic [SEL_W-1:0] sel_o,
   output logic [SHF_W-1:0] shf_o,
   output logic             nz_o
);
   logic [NIB_W-1:0] odd_part;

   always_comb begin
      shf_o = '0;
      for (int i = NIB_W - 1; i >= 0; i--) begin
         if (nib_i[i]) shf_o = SHF_W'(i);
      end
      odd_part = nib_i >> shf_o;
      sel_o    = odd_part[NIB_W-1:1];
      nz_o     = |nib_i;
   end

   // R3: odd code rebuilt and shifted back gives the slice
   always_comb begin
      if (nib_i != '0) begin
         a_r3_encode_inverse : assert ((NIB_W'({sel_o, 1'b1}) << shf_o) == nib_i)
            else $error("encoding does not reproduce slice %b", nib_i);
      end
   end
endmodule

// File: rtl/csm_select_unit.sv
module csm_select_unit #(
   parameter int unsigned X_W   = 8,
   parameter int unsigned NIB_W = 4,
   localparam int unsigned ALPHA_N = 2 ** (NIB_W - 1),
   localparam int unsigned BW      = X_W + NIB_W,
   localparam int unsigned SEL_W   = NIB_W - 1,
   localparam int unsigned SHF_W   = (NIB_W > 2) ? $clog2(NIB_W) : 1
) (
   input  logic [ALPHA_N-1:0][BW-1:0] bank_i,
   input  logic [NIB_W-1:0]           nib_i,
   output logic [BW-1:0]              part_o
);
   logic [SEL_W-1:0] sel;
   logic [SHF_W-1:0] shf;
   logic             nz;
   logic [BW-1:0]    picked;
   logic [BW-1:0]    shifted;

   csm_encoder #(.NIB_W(NIB_W)) enc_i (
      .nib_i (nib_i),
      .sel_o (sel),
      .shf_o (shf),
      .nz_o  (nz)
   );

   assign picked  = bank_i[sel];
   assign shifted = picked << shf;
   assign part_o  = shifted & {BW{nz}};

   // R4: an empty slice yields nothing
   always_comb begin
      if (nib_i == '0) begin
         a_r4_zero_slice : assert (part_o == '0)
            else $error("zero slice produced %0d", part_o);
      end
   end
endmodule

// File: rtl/csm_mult.sv
module csm_mult #(
   parameter int unsigned X_W     = csm_pkg::CSM_DEF_X_W,
   parameter int unsigned C_W     = csm_pkg::CSM_DEF_C_W,
   parameter int unsigned NIB_W   = csm_pkg::CSM_DEF_NIB_W,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned NUM_NIB = C_W / NIB_W,
   localparam int unsigned ALPHA_N = 2 ** (NIB_W - 1),
   localparam int unsigned BW      = X_W + NIB_W,
   localparam int unsigned P_W     = X_W + C_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [X_W-1:0] x_i,
   input  logic [C_W-1:0] c_i,
   output logic [P_W-1:0] prod_o
);
   if (NIB_W < 2) begin : g_bad_nib
      $error("NIB_W must be at least 2");
   end
   if (C_W % NIB_W != 0) begin : g_bad_split
      $error("C_W must be a multiple of NIB_W");
   end

   logic [ALPHA_N-1:0][BW-1:0] bank;
   logic [BW-1:0]              part [NUM_NIB];
   logic [P_W-1:0]             acc  [NUM_NIB+1];

   csm_bank #(.X_W(X_W), .NIB_W(NIB_W)) bank_i (
      .x_i    (x_i),
      .bank_o (bank)
   );

   assign acc[0] = '0;

   for (genvar k = 0; k < NUM_NIB; k++) begin : g_slice
      csm_select_unit #(.X_W(X_W), .NIB_W(NIB_W)) su_i (
         .bank_i (bank),
         .nib_i  (c_i[k*NIB_W +: NIB_W]),
         .part_o (part[k])
      );
      // R5: slice k carries weight 2^(k*NIB_W)
      assign acc[k+1] = acc[k] + (P_W'(part[k]) << (k * NIB_W));
   end

   if (REG_OUT) begin : g_reg
      logic [P_W-1:0] prod_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prod_q <= '0;
         else        prod_q <= acc[NUM_NIB];
      end
      assign prod_o = prod_q;

      // R1 / R7: registered product matches operands of the previous edge
      a_r1_product : assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> prod_o == P_W'($past(x_i)) * P_W'($past(c_i)))
         else $error("registered product mismatch");

      // R2: reset clears the product
      a_r2_reset_clear : assert property (@(posedge clk)
         !rst_n |=> prod_o == '0)
         else $error("product not cleared by reset");
   end else begin : g_comb
      assign prod_o = acc[NUM_NIB];

      // R1: combinational product is exact
      always_comb begin
         a_r1_product_comb : assert (prod_o == P_W'(x_i) * P_W'(c_i))
            else $error("combinational product mismatch");
      end
   end
endmodule

// File: tb/csm_mult_tb.sv
`timescale 1ns/1ps
module csm_mult_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  x = '0;
   logic [7:0]  c = '0;
   logic [15:0] prod;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   csm_mult dut_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .x_i    (x),
      .c_i    (c),
      .prod_o (prod)
   );

   task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%0d exp=%0d", req, got, exp);
      end
   endtask

   // drive at falling edge, result visible after next rising edge
   task automatic apply_and_check(input string req, input logic [7:0] xv, input logic [7:0] cv,
                                  input logic [15:0] exp);
      @(negedge clk);
      x = xv; c = cv;
      @(negedge clk);
      check(req, prod, exp);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      x = 8'hFF; c = 8'hFF;
      repeat (3) @(negedge clk);
      check("R2 reset", prod, 16'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_encoding;
      // R3: slice examples in the low position with x=19
      apply_and_check("R3 0110", 8'd19, 8'h06, 16'd114);
      apply_and_check("R3 1000", 8'd19, 8'h08, 16'd152);
      apply_and_check("R3 1011", 8'd19, 8'h0B, 16'd209);
      apply_and_check("R3 1111", 8'd19, 8'h0F, 16'd285);
      // R3: same slices in the upper position
      apply_and_check("R3 upper 0110", 8'd7, 8'h60, 16'd672);
   endtask

   task automatic t_zero;
      apply_and_check("R4 c=00", 8'd200, 8'h00, 16'd0);
      apply_and_check("R4 c=A0", 8'd200, 8'hA0, 16'd32000);
      apply_and_check("R4 c=05", 8'd200, 8'h05, 16'd1000);
   endtask

   task automatic t_weight;
      apply_and_check("R5 c=E4", 8'd3, 8'hE4, 16'd684);
      apply_and_check("R5 c=10", 8'd255, 8'h10, 16'd4080);
   endtask

   task automatic t_extremes;
      apply_and_check("R6 15x", 8'd255, 8'h0F, 16'd3825);
      apply_and_check("R6 max", 8'd255, 8'hFF, 16'd65025);
      apply_and_check("R6 x=0", 8'd0, 8'hFF, 16'd0);
   endtask

   task automatic t_latency;
      apply_and_check("R7 base", 8'd10, 8'd10, 16'd100);
      @(negedge clk);
      x = 8'd20; c = 8'd30;
      #1;
      check("R7 hold before edge", prod, 16'd100);
      @(negedge clk);
      check("R7 update after edge", prod, 16'd600);
   endtask

   task automatic t_exhaustive;
      logic [15:0] exp_prev;
      int          bad;
      bad = 0;
      @(negedge clk);
      x = 8'd0; c = 8'd0;
      exp_prev = 16'd0;
      for (int i = 1; i <= 65536; i++) begin
         @(negedge clk);
         if (prod !== exp_prev) begin
            bad++;
            if (bad <= 8) $display("FAIL R1 got=%0d exp=%0d", prod, exp_prev);
         end
         if (i < 65536) begin
            x = 8'(i >> 8); c = 8'(i);
            exp_prev = 16'(x) * 16'(c);
         end
      end
      checks++;
      if (bad != 0) failures++;
   endtask

   initial begin
      t_reset;
      t_encoding;
      t_zero;
      t_weight;
      t_extremes;
      t_latency;
      t_exhaustive;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog got=timeout exp=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule